// File: doc/BRIEF.md
# Frame Memory Stage Arbiter

The token-processing element keeps instructions and per-activation frame storage in one single-ported memory. Three clients want it: instruction fetch, the match stage and the output stage. The match stage reads or writes operand data and reads constants. The output stage reads destination words or writes sink results back into the frame. This block sequences the accesses from those stages and allows at most one memory access per clock. It builds the partitioned memory address and drives the enables. It stalls whichever lower-priority client loses, and it reports when each stage has finished its memory work so that the pipeline can advance that stage's latch.

A stage hands over its work as a one-cycle start pulse with a descriptor: activation id, frame id, slot, plus the dyadic/hit/constant flags for the match stage or the instruction mode for the output stage. The descriptor fixes how many memory cycles the stage needs and what each cycle does. The block holds the descriptor and a step counter until all of those cycles have been granted. Alongside this, it compares an incoming token's activation id and slot against the tokens in flight in the match, execute and output stages, and flags any read-after-write hazard on the same frame slot.

Top module: `frame_mem_arbiter`

## Requirements
- R1: At most one memory access is granted per cycle. `mem_gnt` is one-hot or zero, with bit 0 = fetch, bit 1 = match and bit 2 = output. `mem_en` is high only in a cycle with a grant.
- R2: Fixed priority: output stage over match stage over fetch. The output stage never stalls. A requesting match stage or fetch that is not granted raises `m_stall` or `f_stall` in that cycle.
- R3: Match-stage cycle counts are: dyadic token 1 cycle at `slot`, plus 1 constant read at `slot+1` (modulo 64) when `m_const` is set; monadic token 0 cycles, or 1 constant read at `slot` when `m_const` is set.
- R4: The operand access of a dyadic miss (`m_dyadic=1`, `m_hit=0`) is a write (`mem_we=1`). Every other match-stage access is a read.
- R5: Output-stage cycle counts by `o_mode`: modes 4 and 5 make no access; modes 0, 1 and 2 make one read at `slot`; mode 3 makes two reads, at `slot` and then `slot+1` (modulo 64); modes 6 and 7 make one write at `slot`.
- R6: An output descriptor that carries a dyadic miss (`o_dyadic=1`, `o_hit=0`) makes no memory access, whatever its mode.
- R7: A frame access drives `mem_addr = {1'b1, fid[1:0], slot[5:0]}`. A fetch drives `mem_addr = {1'b0, fetch_ofs[7:0]}`.
- R8: A stalled match stage keeps its descriptor and step. In the next cycle it requests the same access again.
- R9: A stage's done pulse comes in the cycle in which its last access is granted. A stage with no accesses pulses done in the cycle after its start. Requests begin in the cycle after the start pulse.
- R10: `raw_haz` bit 0 (match), bit 1 (execute) and bit 2 (output) is set when `in_valid` is high and `in_act`/`in_slot` equal the activation id and slot of a valid token in that stage. A match or output stage counts as valid from the cycle after its start through its done cycle.
- R11: After reset there are no requests, no grants, no enables, no done pulses and no stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Instruction fetch wants the memory this cycle |
| fetch_ofs | input | 8 | Instruction offset |
| m_start | input | 1 | Match stage loads a new descriptor (only while idle) |
| m_dyadic | input | 1 | Match token is dyadic |
| m_hit | input | 1 | Dyadic partner present |
| m_const | input | 1 | Instruction carries a constant |
| m_act | input | 3 | Match token activation id |
| m_fid | input | 2 | Match token frame id |
| m_slot | input | 6 | Match token slot |
| o_start | input | 1 | Output stage loads a new descriptor (only while idle) |
| o_mode | input | 3 | Output instruction mode |
| o_dyadic | input | 1 | Output token was dyadic |
| o_hit | input | 1 | Output token was a dyadic hit |
| o_act | input | 3 | Output token activation id |
| o_fid | input | 2 | Output token frame id |
| o_slot | input | 6 | Output token slot |
| ex_valid | input | 1 | Execute stage holds a token |
| ex_act | input | 3 | Execute token activation id |
| ex_slot | input | 6 | Execute token slot |
| in_valid | input | 1 | Incoming token present |
| in_act | input | 3 | Incoming token activation id |
| in_slot | input | 6 | Incoming token slot |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 9 | Partitioned memory address |
| mem_gnt | output | 3 | One-hot grant: bit 2 output, bit 1 match, bit 0 fetch |
| f_stall | output | 1 | Fetch requested but not granted |
| m_stall | output | 1 | Match stage requested but not granted |
| m_done | output | 1 | Match stage finished its memory work |
| o_done | output | 1 | Output stage finished its memory work |
| raw_haz | output | 3 | Hazard per in-flight stage: bit 2 output, bit 1 execute, bit 0 match |

## Verification
The assertions assume that a stage pulses its start only while idle: a stage is not reloaded before its done pulse or in the cycle of that pulse. The stimulus respects this by waiting for each done before the next start. Conflicts come only from starting the match and output stages together, or from holding a fetch request while the match stage is busy. The hazard inputs are driven only in cycles whose in-flight contents the stimulus has fixed, so the expected hazard bits follow directly from the scenario.

// File: rtl/fma_pkg.sv
package fma_pkg;
  parameter int SLOT_W = 6;
  parameter int FID_W  = 2;
  parameter int ACT_W  = 3;
  parameter int OFS_W  = 8;
  parameter int MODE_W = 3;
  parameter int STEP_W = 2;
  parameter int N_REQ  = 3;

  localparam int FRAME_AW = FID_W + SLOT_W;
  localparam int ADDR_W   = 1 + ((OFS_W > FRAME_AW) ? OFS_W : FRAME_AW);

  // grant vector bit positions, higher index wins
  localparam int G_FETCH = 0;
  localparam int G_MATCH = 1;
  localparam int G_OUT   = 2;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              dyadic;
    logic              hit;
    logic              has_const;
    logic [ACT_W-1:0]  act;
    logic [FID_W-1:0]  fid;
    logic [SLOT_W-1:0] slot;
  } desc_t;

  function automatic logic [STEP_W-1:0] match_cost(input desc_t d);
    return STEP_W'(d.dyadic) + STEP_W'(d.has_const);
  endfunction

  function automatic logic [STEP_W-1:0] out_cost(input desc_t d);
    logic [STEP_W-1:0] c;
    if (d.dyadic && !d.hit) c = '0;
    else begin
      case (d.mode)
        MODE_W'(4), MODE_W'(5): c = '0;
        MODE_W'(3):             c = STEP_W'(2);
        default:                c = STEP_W'(1);
      endcase
    end
    return c;
  endfunction

  function automatic logic match_is_write(input desc_t d, input logic [STEP_W-1:0] step);
    return d.dyadic && !d.hit && (step == '0);
  endfunction

  function automatic logic out_is_write(input desc_t d);
    return (d.mode == MODE_W'(6)) || (d.mode == MODE_W'(7));
  endfunction

  function automatic logic [SLOT_W-1:0] step_slot(input logic [SLOT_W-1:0] s,
                                                  input logic [STEP_W-1:0] step);
    return s + SLOT_W'(step);
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(input logic [FID_W-1:0] f,
                                                   input logic [SLOT_W-1:0] s);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ADDR_W-1] = 1'b1;
    a[FRAME_AW-1:0] = {f, s};
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] fetch_addr(input logic [OFS_W-1:0] o);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[OFS_W-1:0] = o;
    return a;
  endfunction
endpackage

// File: rtl/fma_grant.sv
module fma_grant
  import fma_pkg::*;
#(
  parameter int N = N_REQ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  // a request is granted when no higher-index request is present
  logic [N-1:0] higher;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pri
      if (i == N - 1) begin : g_top
        assign higher[i] = 1'b0;
      end else begin : g_low
        assign higher[i] = |req[N-1:i+1];
      end
      assign gnt[i] = req[i] & ~higher[i];
    end
  endgenerate

  p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_some_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));
endmodule

// File: rtl/fma_seq.sv
module fma_seq
  import fma_pkg::*;
#(
  parameter bit IS_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  desc_t             desc_in,
  input  logic              gnt,
  output logic              busy,
  output logic              req,
  output logic              we,
  output logic              done,
  output logic [ACT_W-1:0]  act_q,
  output logic [FID_W-1:0]  fid_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] acc_slot
);
  desc_t             desc_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] cost;
  logic              last_grant;
  logic              no_work;

  generate
    if (IS_OUT) begin : g_out
      assign cost = out_cost(desc_q);
      assign we   = out_is_write(desc_q);
    end else begin : g_match
      assign cost = match_cost(desc_q);
      assign we   = match_is_write(desc_q, step_q);
    end
  endgenerate

  assign no_work    = (step_q == cost);
  assign req        = busy && !no_work;
  assign last_grant = req && gnt && (step_q + STEP_W'(1) == cost);
  assign done       = busy && (no_work || last_grant);

  assign act_q    = desc_q.act;
  assign fid_q    = desc_q.fid;
  assign slot_q   = desc_q.slot;
  assign acc_slot = step_slot(desc_q.slot, step_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step_q <= '0;
      desc_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        step_q <= '0;
        desc_q <= desc_in;
      end
    end else if (done) begin
      busy   <= 1'b0;
      step_q <= '0;
    end else if (gnt) begin
      step_q <= step_q + STEP_W'(1);
    end
  end

  p_start_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !gnt) |=> (req && $stable(step_q) && $stable(desc_q)));
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_step_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q <= cost));
  p_start_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |-> !req);
endmodule

// File: rtl/fma_hazard.sv
module fma_hazard
  import fma_pkg::*;
#(
  parameter int N_STG = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [ACT_W-1:0]              in_act,
  input  logic [SLOT_W-1:0]             in_slot,
  input  logic [N_STG-1:0]              stg_valid,
  input  logic [N_STG-1:0][ACT_W-1:0]   stg_act,
  input  logic [N_STG-1:0][SLOT_W-1:0]  stg_slot,
  output logic [N_STG-1:0]              haz
);
  generate
    for (genvar i = 0; i < N_STG; i++) begin : g_cmp
      assign haz[i] = in_valid && stg_valid[i] &&
                      (stg_act[i] == in_act) && (stg_slot[i] == in_slot);
    end
  endgenerate

  p_haz_needs_token_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|haz) |-> in_valid);
  p_haz_needs_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (haz & ~stg_valid) == '0);
endmodule

// File: rtl/frame_mem_arbiter.sv
module frame_mem_arbiter
  import fma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [OFS_W-1:0]  fetch_ofs,
  input  logic              m_start,
  input  logic              m_dyadic,
  input  logic              m_hit,
  input  logic              m_const,
  input  logic [ACT_W-1:0]  m_act,
  input  logic [FID_W-1:0]  m_fid,
  input  logic [SLOT_W-1:0] m_slot,
  input  logic              o_start,
  input  logic [MODE_W-1:0] o_mode,
  input  logic              o_dyadic,
  input  logic              o_hit,
  input  logic [ACT_W-1:0]  o_act,
  input  logic [FID_W-1:0]  o_fid,
  input  logic [SLOT_W-1:0] o_slot,
  input  logic              ex_valid,
  input  logic [ACT_W-1:0]  ex_act,
  input  logic [SLOT_W-1:0] ex_slot,
  input  logic              in_valid,
  input  logic [ACT_W-1:0]  in_act,
  input  logic [SLOT_W-1:0] in_slot,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [N_REQ-1:0]  mem_gnt,
  output logic              f_stall,
  output logic              m_stall,
  output logic              m_done,
  output logic              o_done,
  output logic [2:0]        raw_haz
);
  desc_t m_desc_in, o_desc_in;

  always_comb begin
    m_desc_in           = '0;
    m_desc_in.dyadic    = m_dyadic;
    m_desc_in.hit       = m_hit;
    m_desc_in.has_const = m_const;
    m_desc_in.act       = m_act;
    m_desc_in.fid       = m_fid;
    m_desc_in.slot      = m_slot;
    o_desc_in           = '0;
    o_desc_in.mode      = o_mode;
    o_desc_in.dyadic    = o_dyadic;
    o_desc_in.hit       = o_hit;
    o_desc_in.act       = o_act;
    o_desc_in.fid       = o_fid;
    o_desc_in.slot      = o_slot;
  end

  // named internal events
  logic              m_busy, m_req, m_we;
  logic              o_busy, o_req, o_we;
  logic [ACT_W-1:0]  m_act_q, o_act_q;
  logic [FID_W-1:0]  m_fid_q, o_fid_q;
  logic [SLOT_W-1:0] m_slot_q, o_slot_q, m_acc_slot, o_acc_slot;
  logic [N_REQ-1:0]  req_vec;

  fma_seq #(.IS_OUT(1'b0)) u_match (
    .clk(clk), .rst_n(rst_n), .start(m_start), .desc_in(m_desc_in),
    .gnt(mem_gnt[G_MATCH]), .busy(m_busy), .req(m_req), .we(m_we),
    .done(m_done), .act_q(m_act_q), .fid_q(m_fid_q), .slot_q(m_slot_q),
    .acc_slot(m_acc_slot)
  );

  fma_seq #(.IS_OUT(1'b1)) u_out (
    .clk(clk), .rst_n(rst_n), .start(o_start), .desc_in(o_desc_in),
    .gnt(mem_gnt[G_OUT]), .busy(o_busy), .req(o_req), .we(o_we),
    .done(o_done), .act_q(o_act_q), .fid_q(o_fid_q), .slot_q(o_slot_q),
    .acc_slot(o_acc_slot)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[G_FETCH] = fetch_req;
    req_vec[G_MATCH] = m_req;
    req_vec[G_OUT]   = o_req;
  end

  fma_grant #(.N(N_REQ)) u_grant (
    .clk(clk), .rst_n(rst_n), .req(req_vec), .gnt(mem_gnt)
  );

  fma_hazard #(.N_STG(3)) u_haz (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_act(in_act), .in_slot(in_slot),
    .stg_valid({o_busy, ex_valid, m_busy}),
    .stg_act({o_act_q, ex_act, m_act_q}),
    .stg_slot({o_slot_q, ex_slot, m_slot_q}),
    .haz(raw_haz)
  );

  assign mem_en  = |mem_gnt;
  assign m_stall = m_req && !mem_gnt[G_MATCH];
  assign f_stall = fetch_req && !mem_gnt[G_FETCH];

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = '0;
    if (mem_gnt[G_OUT]) begin
      mem_we   = o_we;
      mem_addr = frame_addr(o_fid_q, o_acc_slot);
    end else if (mem_gnt[G_MATCH]) begin
      mem_we   = m_we;
      mem_addr = frame_addr(m_fid_q, m_acc_slot);
    end else if (mem_gnt[G_FETCH]) begin
      mem_addr = fetch_addr(fetch_ofs);
    end
  end

  p_no_en_without_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req || m_req || o_req) |-> !mem_en);
  p_out_never_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_req |-> (mem_en && mem_addr[ADDR_W-1] && mem_gnt[G_OUT]));
  p_fetch_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_gnt[G_FETCH] |-> (!mem_addr[ADDR_W-1] && !mem_we));
  p_frame_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_gnt[G_MATCH] || mem_gnt[G_OUT]) |-> mem_addr[ADDR_W-1]);
  p_we_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  p_stall_then_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_stall && !o_start) |=> (o_req || mem_gnt[G_MATCH]));
endmodule

// File: tb/sim_frame_mem_arbiter.sv
module sim_frame_mem_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       fetch_req = 0;  logic [7:0] fetch_ofs = 0;
  logic       m_start = 0, m_dyadic = 0, m_hit = 0, m_const = 0;
  logic [2:0] m_act = 0;      logic [1:0] m_fid = 0;  logic [5:0] m_slot = 0;
  logic       o_start = 0;    logic [2:0] o_mode = 0;
  logic       o_dyadic = 0, o_hit = 0;
  logic [2:0] o_act = 0;      logic [1:0] o_fid = 0;  logic [5:0] o_slot = 0;
  logic       ex_valid = 0;   logic [2:0] ex_act = 0; logic [5:0] ex_slot = 0;
  logic       in_valid = 0;   logic [2:0] in_act = 0; logic [5:0] in_slot = 0;
  logic       mem_en, mem_we, f_stall, m_stall, m_done, o_done;
  logic [8:0] mem_addr;
  logic [2:0] mem_gnt, raw_haz;

  frame_mem_arbiter u0 (.*);

  typedef struct {
    int        cyc;
    logic [20:0] v;
    string     tag;
  } item_t;
  item_t q[$];

  int cycnt = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always @(posedge clk) cycnt <= cycnt + 1;

  // expected frame address, restated from R7
  function automatic logic [8:0] fa(input int fid, input int slot);
    return 9'h100 + 9'(fid * 64) + 9'(slot % 64);
  endfunction

  task automatic expect_at(input int dc, input bit en, input bit we, input bit [2:0] g,
                           input bit [8:0] a, input bit ms, input bit fs, input bit md,
                           input bit od, input bit [2:0] hz, input string tag);
    item_t it;
    it.cyc = cycnt + dc;
    it.v   = {en, we, g, a, ms, fs, md, od, hz};
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle_at(input int dc, input string tag);
    expect_at(dc, 0, 0, 3'b000, 9'h000, 0, 0, 0, 0, 3'b000, tag);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic start_match(input bit dy, input bit hit, input bit c, input int act,
                             input int fid, input int slot);
    m_start = 1; m_dyadic = dy; m_hit = hit; m_const = c;
    m_act = 3'(act); m_fid = 2'(fid); m_slot = 6'(slot);
  endtask

  task automatic start_out(input int mode, input bit dy, input bit hit, input int act,
                           input int fid, input int slot);
    o_start = 1; o_mode = 3'(mode); o_dyadic = dy; o_hit = hit;
    o_act = 3'(act); o_fid = 2'(fid); o_slot = 6'(slot);
  endtask

  task automatic drain(input int n);
    tick(); m_start = 0; o_start = 0;
    for (int i = 1; i < n; i++) tick();
  endtask

  // monitor: compares the queue head against the outputs away from the edge
  logic [20:0] act_v;
  always @(negedge clk) begin
    act_v = {mem_en, mem_we, mem_gnt, (mem_en ? mem_addr : 9'h000), m_stall, f_stall,
             m_done, o_done, raw_haz};
    while (q.size() > 0 && q[0].cyc < cycnt) begin
      checks++; errors++;
      $display("FAIL %s: expected item for cycle %0d never sampled", q[0].tag, q[0].cyc);
      void'(q.pop_front());
    end
    if (q.size() > 0 && q[0].cyc == cycnt) begin
      checks++;
      if (act_v !== q[0].v) begin
        errors++;
        $display("FAIL %s: cycle %0d actual %h expected %h", q[0].tag, cycnt, act_v, q[0].v);
      end
      void'(q.pop_front());
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // R11: idle after reset
    idle_at(0, "R11 reset idle");
    tick(); tick();

    // R3: dyadic hit with constant, operand at slot then constant at slot+1
    start_match(1, 1, 1, 1, 2, 5);
    idle_at(0, "R9 no request in start cycle");
    expect_at(1, 1, 0, 3'b010, fa(2, 5), 0, 0, 0, 0, 0, "R3 operand read");
    expect_at(2, 1, 0, 3'b010, fa(2, 6), 0, 0, 1, 0, 0, "R3 constant read + R9 done");
    idle_at(3, "R3 finished");
    drain(4);

    // R4: dyadic miss writes the operand
    start_match(1, 0, 0, 2, 1, 10);
    expect_at(1, 1, 1, 3'b010, fa(1, 10), 0, 0, 1, 0, 0, "R4 miss write");
    drain(3);

    // R3: monadic with constant reads slot itself
    start_match(0, 0, 1, 3, 0, 20);
    expect_at(1, 1, 0, 3'b010, fa(0, 20), 0, 0, 1, 0, 0, "R3 monadic const");
    drain(3);

    // R9: monadic without constant is done with no access
    start_match(0, 0, 0, 3, 0, 20);
    expect_at(1, 0, 0, 3'b000, 9'h000, 0, 0, 1, 0, 0, "R9 zero-cycle match done");
    drain(3);

    // R5: mode 3 two reads, slot wraps at 63
    start_out(3, 0, 0, 4, 3, 63);
    expect_at(1, 1, 0, 3'b100, fa(3, 63), 0, 0, 0, 0, 0, "R5 mode3 first");
    expect_at(2, 1, 0, 3'b100, fa(3, 0), 0, 0, 0, 1, 0, "R5 mode3 wrap");
    drain(4);

    // R5: mode 6 writes the result
    start_out(6, 1, 1, 4, 1, 7);
    expect_at(1, 1, 1, 3'b100, fa(1, 7), 0, 0, 0, 1, 0, "R5 mode6 write");
    drain(3);

    // R5: mode 4 no access
    start_out(4, 0, 0, 4, 1, 7);
    expect_at(1, 0, 0, 3'b000, 9'h000, 0, 0, 0, 1, 0, "R5 mode4 no access");
    drain(3);

    // R6: dyadic miss reaching the output stage makes no access
    start_out(0, 1, 0, 4, 1, 7);
    expect_at(1, 0, 0, 3'b000, 9'h000, 0, 0, 0, 1, 0, "R6 miss no output access");
    drain(3);

    // R2/R8: output wins, match stalls and retries the same access
    start_match(1, 1, 1, 1, 2, 5);
    start_out(0, 0, 0, 2, 2, 8);
    expect_at(1, 1, 0, 3'b100, fa(2, 8), 1, 0, 0, 1, 0, "R2 output wins");
    expect_at(2, 1, 0, 3'b010, fa(2, 5), 0, 0, 0, 0, 0, "R8 stalled access repeats");
    expect_at(3, 1, 0, 3'b010, fa(2, 6), 0, 0, 1, 0, 0, "R8 constant after stall");
    drain(5);

    // R7: fetch address partition
    fetch_req = 1; fetch_ofs = 8'h3C;
    expect_at(0, 1, 0, 3'b001, 9'h03C, 0, 0, 0, 0, 0, "R7 fetch address");
    tick(); fetch_req = 0;
    tick();

    // R2: match beats fetch, then fetch is served
    start_match(1, 0, 0, 6, 0, 0);
    tick(); m_start = 0;
    fetch_req = 1; fetch_ofs = 8'hFF;
    expect_at(0, 1, 1, 3'b010, fa(0, 0), 0, 1, 1, 0, 0, "R2 fetch stalls behind match");
    tick();
    expect_at(0, 1, 0, 3'b001, 9'h0FF, 0, 0, 0, 0, 0, "R2 fetch served after match");
    tick(); fetch_req = 0;
    tick();

    // R10: hazards against match, execute and output stages
    start_match(1, 1, 0, 5, 1, 9);
    ex_valid = 1; ex_act = 3'd2; ex_slot = 6'd4;
    in_valid = 1; in_act = 3'd5; in_slot = 6'd9;
    idle_at(0, "R10 match not yet in flight");
    tick(); m_start = 0;
    expect_at(0, 1, 0, 3'b010, fa(1, 9), 0, 0, 1, 0, 3'b001, "R10 match hazard");
    tick();
    in_act = 3'd2; in_slot = 6'd4;
    expect_at(0, 0, 0, 3'b000, 9'h000, 0, 0, 0, 0, 3'b010, "R10 execute hazard");
    tick();
    in_slot = 6'd5;
    idle_at(0, "R10 slot differs");
    tick();
    in_valid = 0; in_slot = 6'd4;
    idle_at(0, "R10 no incoming token");
    tick();
    ex_valid = 0;
    start_out(5, 0, 0, 3, 0, 1);
    in_valid = 1; in_act = 3'd3; in_slot = 6'd1;
    tick(); o_start = 0;
    expect_at(0, 0, 0, 3'b000, 9'h000, 0, 0, 0, 1, 3'b100, "R10 output hazard");
    tick(); in_valid = 0;
    tick(); tick();

    finished = 1;
  end

  initial begin
    while (!finished && cycnt < 20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected finish", cycnt);
    end
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule